// File: doc/BRIEF.md
# Token-Passing Half-Duplex Word Link Port

This block is one end of a point-to-point link between two processors. The two ends share an 8-bit data path that carries bytes in one direction at a time, plus four control signals per end: a byte strobe, a byte acknowledge, a token request and a token pass. Only the end that holds the token may drive the data path. When the other end has words queued, it raises its request. The holder hands the token over as soon as it has nothing left to send. Software never switches the direction.

On the local side the port is a small word-addressed slave. Address 0 accepts words for transmission into an 8-entry queue. Address 1 returns received words from a second 8-entry queue. Address 2 returns ready status. An access that cannot complete (a write while the transmit queue is full, or a read while the receive queue is empty) holds a stall output high until it can complete. Each ready flag also produces an interrupt pulse.

A strap input, sampled while reset is held, picks which end starts as the driver. The two ends of one link must be strapped to opposite roles. Both ends run from a common clock.

Top module: `hdlink_port`

## Requirements
- R1: While reset is held, the port takes its role from `role_drive`: 1 means it owns the token and asserts `lk_d_oe`, 0 means it starts as receiver. After reset the status word reads 1 (transmit ready, receive empty) and `bus_stall` is low.
- R2: `lk_d_oe` and `lk_stb_o` are only ever high at the end that owns the token, so at most one end drives the data path.
- R3: Each 32-bit word crosses the link as four bytes, bits 7:0 first and bits 31:24 last. Every byte uses a four-phase handshake: the strobe rises, the acknowledge rises, the strobe falls, the acknowledge falls. While the strobe waits for its acknowledge, the byte on the data path does not change. A word reaches the receive queue only after all four of its bytes have arrived, and words arrive in the order they were written.
- R4: An end that does not own the token and has queued words raises `lk_req_o` without any software action. The owner gives up the token only when its transmit queue is empty, no byte handshake is open, and the request is present. It signals the hand-over with a one-cycle pulse on `lk_tok_o`, and the receiving end takes ownership on the following edge.
- R5: A write to address 0 while 8 words are queued keeps `bus_stall` high and does not enqueue the word.
- R6: A read from address 1 while the receive queue is empty keeps `bus_stall` high.
- R7: If the receiver never reads, the link holds 16 words: 8 in the receive queue and 8 in the transmit queue. The receiver holds back the acknowledge of a word's last byte until the receive queue has room. The 17th write stalls, and all 16 words are later read out intact and in order.
- R8: Reading address 2 returns bit 0 = transmit queue not full and bit 1 = receive queue not empty, with all other bits zero.
- R9: With the default edge mode, `irq_tx` and `irq_rx` each pulse for one cycle when their ready flag goes from 0 to 1.
- R10: Reset empties both queues, closes any byte in progress, and returns the token to the strapped owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both link ends |
| rst_n | input | 1 | Synchronous active-low reset |
| role_drive | input | 1 | Reset strap: 1 = start as token owner |
| bus_wr | input | 1 | Word write request |
| bus_rd | input | 1 | Word read request |
| bus_addr | input | 2 | Word address: 0 transmit, 1 receive, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_stall | output | 1 | Access cannot complete this cycle |
| irq_tx | output | 1 | Transmit-ready interrupt |
| irq_rx | output | 1 | Receive-ready interrupt |
| lk_d_o | output | 8 | Link byte driven by this end |
| lk_d_oe | output | 1 | Data path enable (token owned) |
| lk_d_i | input | 8 | Link byte seen from the peer |
| lk_stb_o | output | 1 | Byte strobe to peer |
| lk_stb_i | input | 1 | Byte strobe from peer |
| lk_ack_o | output | 1 | Byte acknowledge to peer |
| lk_ack_i | input | 1 | Byte acknowledge from peer |
| lk_req_o | output | 1 | Token request to peer |
| lk_req_i | input | 1 | Token request from peer |
| lk_tok_o | output | 1 | Token pass pulse to peer |
| lk_tok_i | input | 1 | Token pass pulse from peer |

## Verification
The bench wires two ports back to back and checks the following corner cases.

A port that sent bytes in the wrong order, or pushed a word before its fourth byte arrived, would deliver scrambled words. A port that swapped bytes would produce wrong byte values on the monitored data path.

A port that released the token while words were still queued, or never requested it, would either lose words or hang a blocking read.

The 16-word capacity test targets queue depth and last-byte back-pressure. An off-by-one full flag would change the stall point, and an acknowledge that ignored a full receive queue would drop a word.

Resetting with traffic in flight must leave both queues empty and the strapped roles restored.

// File: rtl/hdlink_pkg.sv
package hdlink_pkg;
   // Word addresses of the local slave window
   localparam logic [1:0] LK_ADDR_TXQ  = 2'd0;
   localparam logic [1:0] LK_ADDR_RXQ  = 2'd1;
   localparam logic [1:0] LK_ADDR_STAT = 2'd2;
   // Status word bit positions
   localparam int LK_STAT_TXRDY = 0;
   localparam int LK_STAT_RXRDY = 1;
endpackage

// File: rtl/link_fifo.sv
module link_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic             full,
   output logic             empty,
   output logic [$clog2(DEPTH):0] level
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) begin
            mem[wp[AW-1:0]] <= wdata;
            wp <= wp + 1'b1;
         end
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end

   assign level = wp - rp;
   assign full  = (level == (AW+1)'(DEPTH));
   assign empty = (wp == rp);
   assign rdata = mem[rp[AW-1:0]];
endmodule

// File: rtl/lk_tx_ser.sv
module lk_tx_ser #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own,
   input  logic              have_word,
   input  logic [WORD_W-1:0] word,
   input  logic              ack_i,
   output logic              stb_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              pop,
   output logic              idle
);
   localparam int NB    = WORD_W / BYTE_W;
   localparam int IDX_W = $clog2(NB);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_o <= 1'b0;
         idx   <= '0;
      end else if (!stb_o) begin
         if (own && have_word && !ack_i) stb_o <= 1'b1;
      end else if (ack_i) begin
         stb_o <= 1'b0;
         idx   <= (idx == LAST) ? '0 : idx + 1'b1;
      end
   end

   assign byte_o = word[idx*BYTE_W +: BYTE_W];
   assign pop    = stb_o && ack_i && (idx == LAST);
   assign idle   = !stb_o && !ack_i && (idx == '0);
endmodule

// File: rtl/lk_rx_des.sv
module lk_rx_des #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              room,
   output logic              ack_o,
   output logic              push,
   output logic [WORD_W-1:0] word
);
   localparam int NB    = WORD_W / BYTE_W;
   localparam int IDX_W = $clog2(NB);
   localparam int SH_W  = WORD_W - BYTE_W;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

   logic [IDX_W-1:0] idx;
   logic [SH_W-1:0]  sh;
   logic             take;

   assign word = {byte_i, sh};
   assign take = stb_i && !ack_o && ((idx != LAST) || room);
   assign push = take && (idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_o <= 1'b0;
         idx   <= '0;
         sh    <= '0;
      end else if (take) begin
         ack_o <= 1'b1;
         idx   <= (idx == LAST) ? '0 : idx + 1'b1;
         sh    <= word[WORD_W-1:BYTE_W];
      end else if (!stb_i && ack_o) begin
         ack_o <= 1'b0;
      end
   end
endmodule

// File: rtl/lk_token_arb.sv
module lk_token_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic role_drive,
   input  logic tx_pending,
   input  logic tx_idle,
   input  logic req_i,
   input  logic tok_i,
   output logic own,
   output logic req_o,
   output logic tok_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own   <= role_drive;
         tok_o <= 1'b0;
      end else begin
         tok_o <= 1'b0;
         if (own && !tx_pending && tx_idle && req_i) begin
            own   <= 1'b0;
            tok_o <= 1'b1;
         end else if (!own && tok_i) begin
            own <= 1'b1;
         end
      end
   end

   assign req_o = !own && tx_pending;
endmodule

// File: rtl/hdlink_port.sv
module hdlink_port
   import hdlink_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int FIFO_DEPTH = 8,
   parameter bit IRQ_EDGE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              role_drive,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              bus_stall,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic [BYTE_W-1:0] lk_d_o,
   output logic              lk_d_oe,
   input  logic [BYTE_W-1:0] lk_d_i,
   output logic              lk_stb_o,
   input  logic              lk_stb_i,
   output logic              lk_ack_o,
   input  logic              lk_ack_i,
   output logic              lk_req_o,
   input  logic              lk_req_i,
   output logic              lk_tok_o,
   input  logic              lk_tok_i
);
   localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

   if ((WORD_W % BYTE_W) != 0 || (WORD_W / BYTE_W) < 2) begin : g_bad_width
      $error("hdlink_port: WORD_W must be at least two whole bytes");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hdlink_port: FIFO_DEPTH must be a power of two >= 2");
   end

   logic              own, tx_full, tx_empty, rx_full, rx_empty;
   logic              tx_pop, tx_idle, rx_push;
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;
   logic [LVL_W-1:0]  tx_level, rx_level;
   logic              wr_tx, rd_rx, tx_rdy, rx_rdy;

   assign wr_tx  = bus_wr && (bus_addr == LK_ADDR_TXQ);
   assign rd_rx  = bus_rd && (bus_addr == LK_ADDR_RXQ);
   assign tx_rdy = !tx_full;
   assign rx_rdy = !rx_empty;
   assign bus_stall = (wr_tx && tx_full) || (rd_rx && rx_empty);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == LK_ADDR_RXQ) begin
         bus_rdata = rx_head;
      end else if (bus_addr == LK_ADDR_STAT) begin
         bus_rdata[LK_STAT_TXRDY] = tx_rdy;
         bus_rdata[LK_STAT_RXRDY] = rx_rdy;
      end
   end

   link_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(wr_tx), .wdata(bus_wdata),
      .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
      .level(tx_level));

   link_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
      .pop(rd_rx), .rdata(rx_head), .full(rx_full), .empty(rx_empty),
      .level(rx_level));

   lk_tx_ser #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .own(own), .have_word(!tx_empty),
      .word(tx_head), .ack_i(lk_ack_i), .stb_o(lk_stb_o), .byte_o(lk_d_o),
      .pop(tx_pop), .idle(tx_idle));

   lk_rx_des #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_des (
      .clk(clk), .rst_n(rst_n), .stb_i(lk_stb_i), .byte_i(lk_d_i),
      .room(!rx_full), .ack_o(lk_ack_o), .push(rx_push), .word(rx_word));

   lk_token_arb u_arb (
      .clk(clk), .rst_n(rst_n), .role_drive(role_drive),
      .tx_pending(!tx_empty), .tx_idle(tx_idle), .req_i(lk_req_i),
      .tok_i(lk_tok_i), .own(own), .req_o(lk_req_o), .tok_o(lk_tok_o));

   assign lk_d_oe = own;

   if (IRQ_EDGE) begin : g_irq_edge
      logic tx_rdy_q, rx_rdy_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tx_rdy_q <= 1'b1;
            rx_rdy_q <= 1'b0;
         end else begin
            tx_rdy_q <= tx_rdy;
            rx_rdy_q <= rx_rdy;
         end
      end
      assign irq_tx = tx_rdy && !tx_rdy_q;
      assign irq_rx = rx_rdy && !rx_rdy_q;
   end else begin : g_irq_level
      assign irq_tx = tx_rdy;
      assign irq_rx = rx_rdy;
   end
endmodule

// File: rtl/hdlink_port_chk.sv
module hdlink_port_chk
   import hdlink_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter bit IRQ_EDGE = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_wr,
   input logic                    bus_rd,
   input logic [1:0]              bus_addr,
   input logic                    bus_stall,
   input logic                    irq_rx,
   input logic                    irq_tx,
   input logic [7:0]              lk_d_o,
   input logic                    lk_d_oe,
   input logic                    lk_stb_o,
   input logic                    lk_ack_i,
   input logic                    lk_req_i,
   input logic                    tx_empty,
   input logic [$clog2(DEPTH):0]  tx_level,
   input logic [$clog2(DEPTH):0]  rx_level
);
   localparam int LW = $clog2(DEPTH) + 1;

   // R2: strobing requires the token
   a_r2_strobe_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
      lk_stb_o |-> lk_d_oe);

   // R3: byte held until acknowledged
   a_r3_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_stb_o && !lk_ack_i) |=> (lk_stb_o && $stable(lk_d_o)));

   // R4: token released only with empty queue on request
   a_r4_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lk_d_oe) |-> $past(tx_empty && lk_req_i));

   // R5: full transmit queue stalls a write
   a_r5_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == LK_ADDR_TXQ && tx_level == LW'(DEPTH)) |-> bus_stall);

   // R6: empty receive queue stalls a read
   a_r6_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == LK_ADDR_RXQ && rx_level == '0) |-> bus_stall);

   // R7: receive queue never exceeds its depth
   a_r7_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= LW'(DEPTH));

   if (IRQ_EDGE) begin : g_pulse
      // R9: interrupts are single-cycle pulses
      a_r9_irq_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         irq_rx |=> !irq_rx);
      a_r9_irq_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         irq_tx |=> !irq_tx);
   end
endmodule

bind hdlink_port hdlink_port_chk #(.DEPTH(FIFO_DEPTH), .IRQ_EDGE(IRQ_EDGE)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_stall(bus_stall), .irq_rx(irq_rx), .irq_tx(irq_tx),
   .lk_d_o(lk_d_o), .lk_d_oe(lk_d_oe), .lk_stb_o(lk_stb_o), .lk_ack_i(lk_ack_i),
   .lk_req_i(lk_req_i), .tx_empty(tx_empty), .tx_level(tx_level),
   .rx_level(rx_level));

// File: tb/hdlink_port_tb.sv
`timescale 1ns/1ps
module hdlink_port_tb;
   import hdlink_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        b_wr [2];
   logic        b_rd [2];
   logic [1:0]  b_addr [2];
   logic [31:0] b_wdata [2];
   logic [31:0] b_rdata [2];
   logic        b_stall [2];
   logic        irq_tx [2];
   logic        irq_rx [2];
   logic [7:0]  d_o [2];
   logic [7:0]  d_i [2];
   logic        oe [2], stb [2], ack [2], req [2], tok [2];

   assign d_i[0] = oe[1] ? d_o[1] : 8'h00;
   assign d_i[1] = oe[0] ? d_o[0] : 8'h00;

   hdlink_port u_dut (
      .clk(clk), .rst_n(rst_n), .role_drive(1'b1),
      .bus_wr(b_wr[0]), .bus_rd(b_rd[0]), .bus_addr(b_addr[0]),
      .bus_wdata(b_wdata[0]), .bus_rdata(b_rdata[0]), .bus_stall(b_stall[0]),
      .irq_tx(irq_tx[0]), .irq_rx(irq_rx[0]),
      .lk_d_o(d_o[0]), .lk_d_oe(oe[0]), .lk_d_i(d_i[0]),
      .lk_stb_o(stb[0]), .lk_stb_i(stb[1]), .lk_ack_o(ack[0]), .lk_ack_i(ack[1]),
      .lk_req_o(req[0]), .lk_req_i(req[1]), .lk_tok_o(tok[0]), .lk_tok_i(tok[1]));

   hdlink_port u_peer (
      .clk(clk), .rst_n(rst_n), .role_drive(1'b0),
      .bus_wr(b_wr[1]), .bus_rd(b_rd[1]), .bus_addr(b_addr[1]),
      .bus_wdata(b_wdata[1]), .bus_rdata(b_rdata[1]), .bus_stall(b_stall[1]),
      .irq_tx(irq_tx[1]), .irq_rx(irq_rx[1]),
      .lk_d_o(d_o[1]), .lk_d_oe(oe[1]), .lk_d_i(d_i[1]),
      .lk_stb_o(stb[1]), .lk_stb_i(stb[0]), .lk_ack_o(ack[1]), .lk_ack_i(ack[0]),
      .lk_req_o(req[1]), .lk_req_i(req[0]), .lk_tok_o(tok[1]), .lk_tok_i(tok[0]));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // Byte monitor on the driving end's data path
   logic [7:0] seen [4];
   int         nseen = 0;
   bit         mon_en = 0;
   logic       stb_q = 1'b0;
   int         irq_rx_cnt = 0;
   always @(negedge clk) begin
      if (mon_en && stb[0] && !stb_q && nseen < 4) begin
         seen[nseen] = d_o[0];
         nseen++;
      end
      stb_q = stb[0];
      if (irq_rx[1]) irq_rx_cnt++;
   end

   function automatic logic [31:0] stat_word(input bit txr, input bit rxr);
      logic [31:0] v = '0;
      v[LK_STAT_TXRDY] = txr;
      v[LK_STAT_RXRDY] = rxr;
      return v;
   endfunction

   task automatic bus_write(input int s, input logic [31:0] d);
      @(negedge clk);
      b_addr[s] = LK_ADDR_TXQ; b_wdata[s] = d; b_wr[s] = 1'b1;
      #1;
      while (b_stall[s]) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      b_wr[s] = 1'b0;
   endtask

   task automatic bus_read(input int s, input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      b_addr[s] = a; b_rd[s] = 1'b1;
      #1;
      while (b_stall[s]) begin @(negedge clk); #1; end
      d = b_rdata[s];
      @(posedge clk); #1;
      b_rd[s] = 1'b0;
   endtask

   task automatic try_access(input int s, input bit wr, output logic st);
      @(negedge clk);
      if (wr) begin b_addr[s] = LK_ADDR_TXQ; b_wdata[s] = 32'hDEAD_0000; b_wr[s] = 1'b1; end
      else    begin b_addr[s] = LK_ADDR_RXQ; b_rd[s] = 1'b1; end
      #1;
      st = b_stall[s];
      b_wr[s] = 1'b0; b_rd[s] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, wq [16];
      logic        st;
      void'($urandom(32'd5150));
      for (int s = 0; s < 2; s++) begin
         b_wr[s] = 0; b_rd[s] = 0; b_addr[s] = 0; b_wdata[s] = 0;
      end
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(2);

      // R1 / R8: reset state
      check("R1 dut owns", {31'b0, oe[0]}, 32'd1);
      check("R1 peer receiver", {31'b0, oe[1]}, 32'd0);
      bus_read(0, LK_ADDR_STAT, rd); check("R8 dut status", rd, stat_word(1, 0));
      bus_read(1, LK_ADDR_STAT, rd); check("R1 peer status", rd, stat_word(1, 0));

      // R6: empty read stalls
      try_access(0, 1'b0, st); check("R6 empty read stall", {31'b0, st}, 32'd1);

      // R3 byte order, R9 interrupt
      mon_en = 1;
      bus_write(0, 32'h1122_3344);
      bus_read(1, LK_ADDR_RXQ, rd);
      check("R3 word", rd, 32'h1122_3344);
      check("R3 byte0", {24'b0, seen[0]}, 32'h44);
      check("R3 byte1", {24'b0, seen[1]}, 32'h33);
      check("R3 byte2", {24'b0, seen[2]}, 32'h22);
      check("R3 byte3", {24'b0, seen[3]}, 32'h11);
      mon_en = 0;
      idle(2);
      check("R9 rx irq once", irq_rx_cnt, 32'd1);

      // R3 random burst in order
      for (int i = 0; i < 6; i++) begin wq[i] = $urandom; bus_write(0, wq[i]); end
      for (int i = 0; i < 6; i++) begin bus_read(1, LK_ADDR_RXQ, rd); check("R3 burst", rd, wq[i]); end

      // R4 turnaround both ways
      bus_write(1, 32'hCAFE_0001);
      bus_read(0, LK_ADDR_RXQ, rd);
      check("R4 reverse word", rd, 32'hCAFE_0001);
      check("R4 peer owns", {31'b0, oe[1]}, 32'd1);
      check("R4 dut released", {31'b0, oe[0]}, 32'd0);
      bus_write(0, 32'hBEEF_0002);
      bus_read(1, LK_ADDR_RXQ, rd);
      check("R4 forward again", rd, 32'hBEEF_0002);
      check("R4 dut owns again", {31'b0, oe[0]}, 32'd1);

      // R5 / R7: sixteen words held, seventeenth stalls
      for (int i = 0; i < 16; i++) begin wq[i] = $urandom; bus_write(0, wq[i]); end
      idle(200);
      try_access(0, 1'b1, st); check("R5 full write stall", {31'b0, st}, 32'd1);
      bus_read(1, LK_ADDR_STAT, rd); check("R7 peer rx ready", rd, stat_word(1, 1));
      for (int i = 0; i < 16; i++) begin bus_read(1, LK_ADDR_RXQ, rd); check("R7 capacity order", rd, wq[i]); end

      // Random mixed directions (R3, R4)
      for (int it = 0; it < 10; it++) begin
         int s = int'($urandom % 2);
         int n = 1 + int'($urandom % 4);
         for (int i = 0; i < n; i++) begin wq[i] = $urandom; bus_write(s, wq[i]); end
         for (int i = 0; i < n; i++) begin bus_read(1 - s, LK_ADDR_RXQ, rd); check("R4 mixed", rd, wq[i]); end
      end

      // R10: reset with traffic in flight
      bus_write(1, 32'h0000_0A0A);
      bus_write(0, 32'h1234_0001);
      bus_write(0, 32'h1234_0002);
      bus_write(0, 32'h1234_0003);
      @(negedge clk); rst_n = 1'b0;
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      bus_read(1, LK_ADDR_STAT, rd); check("R10 peer cleared", rd, stat_word(1, 0));
      bus_read(0, LK_ADDR_STAT, rd); check("R10 dut cleared", rd, stat_word(1, 0));
      check("R10 role restored", {30'b0, oe[0], oe[1]}, 32'd2);
      try_access(1, 1'b0, st); check("R10 peer read stalls", {31'b0, st}, 32'd1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule